// File: doc/BRIEF.md
# Shared Disk Word-Transfer Channel

This block moves 16-bit words between system memory and one of two byte-wide disk controllers, a floppy controller and a hard-disk controller. Two drive-select inputs choose which controller the channel serves. In the disk-to-memory direction the channel reads two bytes and assembles them into one word, high byte first. In the memory-to-disk direction it reads one word and sends it out as two bytes, high byte first. Each byte move waits for the selected controller's data request.

Software starts a transfer with a pulse that loads a logical byte address, a starting word count and a direction. Before each word the channel shows its current logical address to an external translator. The translator answers with a physical address and an access verdict. The channel sends each physical address either to base RAM or to expansion RAM, or to nothing when the address hits no populated RAM. After each word it adds one to the count. The transfer ends when the count would reach the terminal value, and the count is then held one below it. The transfer also ends early when an access check fails.

While the channel is idle, a data request from a controller produces a missed-transfer strobe back to that controller. The block also encodes the interrupt level presented to the processor, based on the two disk interrupts and the keyboard interrupt.

Top module: `disk_dma_channel`

## Requirements
- R1: When `sel_fd` is high the floppy controller is used; otherwise, when `sel_hd` is high, the hard-disk controller is used. Byte strobes never go to the controller that is not in use.
- R2: While the controller in use holds its data request low, the channel issues no byte strobe, makes no memory write and leaves the count unchanged.
- R3: Disk to memory (`to_disk`=0): the first byte taken becomes bits 15:8 and the second byte becomes bits 7:0 of the word written to memory.
- R4: Memory to disk (`to_disk`=1): bits 15:8 of the memory word go to the controller first, then bits 7:0.
- R5: A physical byte address below 0x200000 selects base RAM at word address paddr[21:1]. A physical byte address at or above 0x200000 selects expansion RAM at word address (paddr−0x200000)[21:1]. At most one bank is selected in any cycle.
- R6: An address beyond the populated size of its bank (base 0x200000 bytes, expansion 0x100000 bytes by default) produces no memory cycle. A read of such an address yields 0xFFFF, and a write to it is dropped while the transfer still advances.
- R7: Each completed word adds 2 to the logical byte address and 1 to the count. When the count would reach 0x4000, the count is set to 0x3FFF and `dma_busy` falls.
- R8: If `xlat_ok` is low when a word begins, the transfer stops with `dma_busy` low. That word has no memory cycle and no byte strobe, and the count and address keep their values.
- R9: While `dma_busy` is low, a high `hd_drq` gives `hd_miss` one cycle later. Otherwise a high `fd_drq` gives `fd_miss` one cycle later. The hard-disk controller takes precedence.
- R10: One cycle after the inputs change, `irq_level` is 2 when `fd_irq` or `hd_irq` is high, else 3 when `kbd_irq` is high, else 0.
- R11: A word attempted with neither drive selected sets the sticky flag `err_nosel` and moves no data. Only reset or a new start clears the flag.
- R12: After reset `dma_busy`, `dma_count`, `irq_level`, `err_nosel`, both miss strobes and all memory and byte strobes are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Load address, count and direction, and begin a transfer |
| to_disk | input | 1 | Direction: 1 memory to disk, 0 disk to memory |
| start_addr | input | 22 | Starting logical byte address |
| start_count | input | 14 | Starting word count |
| sel_fd | input | 1 | Floppy drive selected |
| sel_hd | input | 1 | Hard-disk drive selected |
| fd_drq | input | 1 | Floppy controller data request |
| fd_rdata | input | 8 | Floppy controller byte at the head of its data port |
| fd_rd_stb | output | 1 | Take one byte from the floppy controller |
| fd_wr_stb | output | 1 | Give one byte to the floppy controller |
| fd_miss | output | 1 | Missed-transfer strobe to the floppy controller |
| hd_drq | input | 1 | Hard-disk controller data request |
| hd_rdata | input | 8 | Hard-disk controller byte at the head of its data port |
| hd_rd_stb | output | 1 | Take one byte from the hard-disk controller |
| hd_wr_stb | output | 1 | Give one byte to the hard-disk controller |
| hd_miss | output | 1 | Missed-transfer strobe to the hard-disk controller |
| ctl_wdata | output | 8 | Byte sent with either write strobe |
| fd_irq | input | 1 | Floppy controller interrupt |
| hd_irq | input | 1 | Hard-disk controller interrupt |
| kbd_irq | input | 1 | Keyboard interrupt |
| irq_level | output | 3 | Encoded interrupt level to the processor |
| xlat_laddr | output | 22 | Current logical byte address |
| xlat_paddr | input | 22 | Translated physical byte address |
| xlat_ok | input | 1 | Access check passed for the current address |
| base_cs | output | 1 | Base RAM cycle |
| exp_cs | output | 1 | Expansion RAM cycle |
| mem_we | output | 1 | Memory cycle is a write |
| mem_addr | output | 21 | Word address inside the selected bank |
| mem_wdata | output | 16 | Word to write |
| base_rdata | input | 16 | Base RAM read data, one cycle after the cycle |
| exp_rdata | input | 16 | Expansion RAM read data, one cycle after the cycle |
| dma_busy | output | 1 | Transfer in progress |
| dma_count | output | 15 | Word count |
| err_nosel | output | 1 | Sticky flag: transfer attempted with no drive selected |

## Verification
The interrupt encoder and the missed-transfer logic run on every cycle, independent of the transfer sequencer. Two cases therefore overlap: a disk interrupt arrives during a transfer, and a controller still raises its request at the moment a transfer ends. The bench starts transfers with both controllers holding queued bytes and asserts interrupts before those transfers begin. It then checks that every byte and memory word appears in the expected order. Miss strobes are checked to appear only once the channel is idle, with the hard-disk controller preferred when both request.

// File: rtl/dma_chan_pkg.sv
// Package: types and constants shared by the disk word-transfer channel.
// Assumes: nothing beyond IEEE 1800-2017.
package dma_chan_pkg;

    // Sequencer states for one word move
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_REQ   = 3'd1,
        ST_LO_IN = 3'd2,
        ST_RDWAIT = 3'd3,
        ST_HI_OUT = 3'd4,
        ST_LO_OUT = 3'd5
    } seq_state_t;

    // Which bank a pending memory read went to
    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_BASE = 2'd1,
        SRC_EXP  = 2'd2
    } rd_src_t;

    localparam logic [2:0] IRQ_LVL_DISK = 3'd2;
    localparam logic [2:0] IRQ_LVL_KBD  = 3'd3;
    localparam logic [2:0] IRQ_LVL_NONE = 3'd0;
    localparam logic [15:0] OPEN_BUS_WORD = 16'hFFFF;

endpackage

// File: rtl/dma_ctrl_mux.sv
// Module: picks the controller in use from the drive selects and routes
// its request, read byte and strobes. Floppy wins when both are selected.
// Assumes: strobes are single-cycle and qualified by the caller with drq.
module dma_ctrl_mux (
    input  logic       sel_fd,
    input  logic       sel_hd,
    input  logic       fd_drq,
    input  logic [7:0] fd_rdata,
    input  logic       hd_drq,
    input  logic [7:0] hd_rdata,
    input  logic       pop,
    input  logic       push,
    output logic       sel_any,
    output logic       drq,
    output logic [7:0] rbyte,
    output logic       fd_rd_stb,
    output logic       fd_wr_stb,
    output logic       hd_rd_stb,
    output logic       hd_wr_stb
);
    logic use_fd;
    logic use_hd;

    // Resolve the active controller with floppy priority
    always_comb begin
        use_fd  = sel_fd;
        use_hd  = !sel_fd && sel_hd;
        sel_any = use_fd || use_hd;
    end

    // Route request and read byte from the active controller
    always_comb begin
        if (use_fd) begin
            drq   = fd_drq;
            rbyte = fd_rdata;
        end else if (use_hd) begin
            drq   = hd_drq;
            rbyte = hd_rdata;
        end else begin
            drq   = 1'b0;
            rbyte = 8'h00;
        end
    end

    // Steer the byte strobes to the active controller only
    always_comb begin
        fd_rd_stb = use_fd && pop;
        fd_wr_stb = use_fd && push;
        hd_rd_stb = use_hd && pop;
        hd_wr_stb = use_hd && push;
    end
endmodule

// File: rtl/dma_mem_steer.sv
// Module: decodes a physical byte address into a base or expansion bank hit
// and a word address inside that bank; unpopulated space hits neither.
// Assumes: BASE_SPLIT is the start of expansion space; sizes are in bytes.
module dma_mem_steer #(
    parameter int unsigned AW         = 22,
    parameter int unsigned BASE_SPLIT = 32'h0020_0000,
    parameter int unsigned BASE_BYTES = 32'h0020_0000,
    parameter int unsigned EXP_BYTES  = 32'h0010_0000
) (
    input  logic [AW-1:0] paddr,
    output logic          hit_base,
    output logic          hit_exp,
    output logic [AW-2:0] bank_addr
);
    localparam logic [AW:0] SPLIT_W = (AW+1)'(BASE_SPLIT);
    localparam logic [AW:0] BLIM_W  = (AW+1)'(BASE_BYTES);
    localparam logic [AW:0] ELIM_W  = (AW+1)'(EXP_BYTES);

    logic [AW:0]   pa_ext;
    logic [AW:0]   exp_off;
    logic          in_exp_space;
    logic          unused_lsb;

    // Widen the address and form the expansion offset
    always_comb begin
        pa_ext       = {1'b0, paddr};
        exp_off      = pa_ext - SPLIT_W;
        in_exp_space = pa_ext >= SPLIT_W;
    end

    // Decide which bank, if any, is populated at this address
    always_comb begin
        hit_base = !in_exp_space && (pa_ext < BLIM_W);
        hit_exp  = in_exp_space && (exp_off < ELIM_W);
    end

    // Word address inside the chosen bank
    always_comb begin
        bank_addr = in_exp_space ? exp_off[AW-1:1] : paddr[AW-1:1];
    end

    assign unused_lsb = exp_off[0] ^ exp_off[AW];
endmodule

// File: rtl/dma_notify.sv
// Module: registered missed-transfer strobes and interrupt-level encoder.
// Assumes: busy comes from the sequencer; all outputs lag inputs by a cycle.
module dma_notify
    import dma_chan_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       busy,
    input  logic       fd_drq,
    input  logic       hd_drq,
    input  logic       fd_irq,
    input  logic       hd_irq,
    input  logic       kbd_irq,
    output logic       fd_miss,
    output logic       hd_miss,
    output logic [2:0] irq_level
);
    // Flag a request that arrives while no transfer runs, hard disk first
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fd_miss <= 1'b0;
            hd_miss <= 1'b0;
        end else begin
            hd_miss <= !busy && hd_drq;
            fd_miss <= !busy && !hd_drq && fd_drq;
        end
    end

    // Encode the processor interrupt level with disk above keyboard
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_level <= IRQ_LVL_NONE;
        end else if (fd_irq || hd_irq) begin
            irq_level <= IRQ_LVL_DISK;
        end else if (kbd_irq) begin
            irq_level <= IRQ_LVL_KBD;
        end else begin
            irq_level <= IRQ_LVL_NONE;
        end
    end
endmodule

// File: rtl/dma_seq.sv
// Module: word sequencer. Checks access and request, packs or unpacks byte
// pairs high byte first, runs one memory cycle per word, advances address
// and count, and stops at the terminal count or on a failed access check.
// Assumes: memory read data arrives one cycle after the read cycle; the
// translated address is stable while the logical address is unchanged.
module dma_seq
    import dma_chan_pkg::*;
#(
    parameter int unsigned AW      = 22,
    parameter int unsigned CNT_END = 16384,
    localparam int unsigned CW     = $clog2(CNT_END) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          to_disk,
    input  logic [AW-1:0] start_addr,
    input  logic [CW-2:0] start_count,
    input  logic          sel_any,
    input  logic          drq,
    input  logic [7:0]    rbyte,
    input  logic          xlat_ok,
    input  logic          hit_base,
    input  logic          hit_exp,
    input  logic [15:0]   base_rdata,
    input  logic [15:0]   exp_rdata,
    output logic          pop,
    output logic          push,
    output logic [7:0]    wbyte,
    output logic          base_cs,
    output logic          exp_cs,
    output logic          mem_we,
    output logic [15:0]   mem_wdata,
    output logic [AW-1:0] laddr,
    output logic [CW-1:0] count,
    output logic          busy,
    output logic          err_nosel
);
    localparam logic [CW-1:0] CNT_LAST = CW'(CNT_END - 1);
    localparam logic [AW-1:0] ADDR_STEP = AW'(2);

    seq_state_t state;
    rd_src_t    rd_src;
    logic       dir_out;
    logic [7:0] hi_byte;
    logic [15:0] word_q;
    logic       step;
    logic       begin_ok;

    // A word may begin only with a controller selected and requesting
    always_comb begin
        begin_ok = (state == ST_REQ) && sel_any && drq && xlat_ok;
    end

    // Strobes, memory cycle and word completion for the current state
    always_comb begin
        pop       = 1'b0;
        push      = 1'b0;
        wbyte     = word_q[7:0];
        base_cs   = 1'b0;
        exp_cs    = 1'b0;
        mem_we    = 1'b0;
        mem_wdata = {hi_byte, rbyte};
        step      = 1'b0;
        unique case (state)
            ST_REQ: begin
                if (begin_ok) begin
                    if (!dir_out) begin
                        pop = 1'b1;
                    end else begin
                        base_cs = hit_base;
                        exp_cs  = hit_exp;
                    end
                end
            end
            ST_LO_IN: begin
                if (drq) begin
                    pop     = 1'b1;
                    base_cs = hit_base;
                    exp_cs  = hit_exp;
                    mem_we  = 1'b1;
                    step    = 1'b1;
                end
            end
            ST_HI_OUT: begin
                if (drq) begin
                    push  = 1'b1;
                    wbyte = word_q[15:8];
                end
            end
            ST_LO_OUT: begin
                if (drq) begin
                    push  = 1'b1;
                    wbyte = word_q[7:0];
                    step  = 1'b1;
                end
            end
            default: begin
            end
        endcase
    end

    assign busy = (state != ST_IDLE);

    // State, address, count and flag updates
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            rd_src    <= SRC_NONE;
            dir_out   <= 1'b0;
            hi_byte   <= 8'h00;
            word_q    <= 16'h0000;
            laddr     <= '0;
            count     <= '0;
            err_nosel <= 1'b0;
        end else if (start) begin
            state     <= ST_REQ;
            dir_out   <= to_disk;
            laddr     <= start_addr;
            count     <= {1'b0, start_count};
            err_nosel <= 1'b0;
        end else begin
            unique case (state)
                ST_REQ: begin
                    if (!sel_any) begin
                        err_nosel <= 1'b1;
                    end else if (drq && !xlat_ok) begin
                        state <= ST_IDLE;
                    end else if (begin_ok && !dir_out) begin
                        hi_byte <= rbyte;
                        state   <= ST_LO_IN;
                    end else if (begin_ok) begin
                        rd_src <= hit_base ? SRC_BASE : (hit_exp ? SRC_EXP : SRC_NONE);
                        state  <= ST_RDWAIT;
                    end
                end
                ST_RDWAIT: begin
                    unique case (rd_src)
                        SRC_BASE: word_q <= base_rdata;
                        SRC_EXP:  word_q <= exp_rdata;
                        default:  word_q <= OPEN_BUS_WORD;
                    endcase
                    state <= ST_HI_OUT;
                end
                ST_HI_OUT: begin
                    if (drq) begin
                        state <= ST_LO_OUT;
                    end
                end
                default: begin
                end
            endcase
            if (step) begin
                laddr <= laddr + ADDR_STEP;
                if (count == CNT_LAST) begin
                    count <= CNT_LAST;
                    state <= ST_IDLE;
                end else begin
                    count <= count + CW'(1);
                    state <= ST_REQ;
                end
            end
        end
    end
endmodule

// File: rtl/disk_dma_channel.sv
// Module: top of the shared disk word-transfer channel. Wires the controller
// selector, address steering, word sequencer and notification logic.
// Assumes: the translator answers combinationally from xlat_laddr.
module disk_dma_channel #(
    parameter int unsigned AW         = 22,
    parameter int unsigned CNT_END    = 16384,
    parameter int unsigned BASE_SPLIT = 32'h0020_0000,
    parameter int unsigned BASE_BYTES = 32'h0020_0000,
    parameter int unsigned EXP_BYTES  = 32'h0010_0000,
    localparam int unsigned CW        = $clog2(CNT_END) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          to_disk,
    input  logic [AW-1:0] start_addr,
    input  logic [CW-2:0] start_count,
    input  logic          sel_fd,
    input  logic          sel_hd,
    input  logic          fd_drq,
    input  logic [7:0]    fd_rdata,
    output logic          fd_rd_stb,
    output logic          fd_wr_stb,
    output logic          fd_miss,
    input  logic          hd_drq,
    input  logic [7:0]    hd_rdata,
    output logic          hd_rd_stb,
    output logic          hd_wr_stb,
    output logic          hd_miss,
    output logic [7:0]    ctl_wdata,
    input  logic          fd_irq,
    input  logic          hd_irq,
    input  logic          kbd_irq,
    output logic [2:0]    irq_level,
    output logic [AW-1:0] xlat_laddr,
    input  logic [AW-1:0] xlat_paddr,
    input  logic          xlat_ok,
    output logic          base_cs,
    output logic          exp_cs,
    output logic          mem_we,
    output logic [AW-2:0] mem_addr,
    output logic [15:0]   mem_wdata,
    input  logic [15:0]   base_rdata,
    input  logic [15:0]   exp_rdata,
    output logic          dma_busy,
    output logic [CW-1:0] dma_count,
    output logic          err_nosel
);
    logic       sel_any;
    logic       drq;
    logic [7:0] rbyte;
    logic       pop;
    logic       push;
    logic       hit_base;
    logic       hit_exp;

    dma_ctrl_mux u_mux (
        .sel_fd    (sel_fd),
        .sel_hd    (sel_hd),
        .fd_drq    (fd_drq),
        .fd_rdata  (fd_rdata),
        .hd_drq    (hd_drq),
        .hd_rdata  (hd_rdata),
        .pop       (pop),
        .push      (push),
        .sel_any   (sel_any),
        .drq       (drq),
        .rbyte     (rbyte),
        .fd_rd_stb (fd_rd_stb),
        .fd_wr_stb (fd_wr_stb),
        .hd_rd_stb (hd_rd_stb),
        .hd_wr_stb (hd_wr_stb)
    );

    dma_mem_steer #(
        .AW         (AW),
        .BASE_SPLIT (BASE_SPLIT),
        .BASE_BYTES (BASE_BYTES),
        .EXP_BYTES  (EXP_BYTES)
    ) u_steer (
        .paddr     (xlat_paddr),
        .hit_base  (hit_base),
        .hit_exp   (hit_exp),
        .bank_addr (mem_addr)
    );

    dma_seq #(
        .AW      (AW),
        .CNT_END (CNT_END)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .to_disk     (to_disk),
        .start_addr  (start_addr),
        .start_count (start_count),
        .sel_any     (sel_any),
        .drq         (drq),
        .rbyte       (rbyte),
        .xlat_ok     (xlat_ok),
        .hit_base    (hit_base),
        .hit_exp     (hit_exp),
        .base_rdata  (base_rdata),
        .exp_rdata   (exp_rdata),
        .pop         (pop),
        .push        (push),
        .wbyte       (ctl_wdata),
        .base_cs     (base_cs),
        .exp_cs      (exp_cs),
        .mem_we      (mem_we),
        .mem_wdata   (mem_wdata),
        .laddr       (xlat_laddr),
        .count       (dma_count),
        .busy        (dma_busy),
        .err_nosel   (err_nosel)
    );

    dma_notify u_notify (
        .clk       (clk),
        .rst_n     (rst_n),
        .busy      (dma_busy),
        .fd_drq    (fd_drq),
        .hd_drq    (hd_drq),
        .fd_irq    (fd_irq),
        .hd_irq    (hd_irq),
        .kbd_irq   (kbd_irq),
        .fd_miss   (fd_miss),
        .hd_miss   (hd_miss),
        .irq_level (irq_level)
    );
endmodule

// File: rtl/disk_dma_channel_chk.sv
// Module: property checker for disk_dma_channel, attached by bind.
// Assumes: port names match the top module so the bind can use .*.
module disk_dma_channel_chk #(
    parameter int unsigned CW = 15
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          sel_fd,
    input logic          sel_hd,
    input logic          fd_drq,
    input logic          hd_drq,
    input logic          fd_rd_stb,
    input logic          fd_wr_stb,
    input logic          hd_rd_stb,
    input logic          hd_wr_stb,
    input logic          fd_miss,
    input logic          hd_miss,
    input logic          fd_irq,
    input logic          hd_irq,
    input logic [2:0]    irq_level,
    input logic          base_cs,
    input logic          exp_cs,
    input logic          dma_busy,
    input logic [CW-1:0] dma_count,
    input logic          err_nosel
);
    localparam logic [CW-1:0] CNT_LAST = {1'b0, {(CW-1){1'b1}}};

    AST_FD_STB_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        (fd_rd_stb || fd_wr_stb) |-> sel_fd); // R1
    AST_HD_STB_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        (hd_rd_stb || hd_wr_stb) |-> (sel_hd && !sel_fd)); // R1
    AST_FD_STB_NEEDS_DRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (fd_rd_stb || fd_wr_stb) |-> fd_drq); // R2
    AST_HD_STB_NEEDS_DRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (hd_rd_stb || hd_wr_stb) |-> hd_drq); // R2
    AST_ONE_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({base_cs, exp_cs})); // R5
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(start) && (dma_count != $past(dma_count)))
            |-> ((dma_count == $past(dma_count) + 1'b1) || (dma_count == CNT_LAST))); // R7
    AST_MISS_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (fd_miss || hd_miss) |-> !$past(dma_busy)); // R9
    AST_MISS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fd_miss, hd_miss})); // R9
    AST_HD_MISS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        hd_miss |-> $past(hd_drq)); // R9
    AST_DISK_IRQ_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_level == 3'd2) |-> $past(fd_irq || hd_irq)); // R10
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(err_nosel) && !$past(start)) |-> err_nosel); // R11
endmodule

bind disk_dma_channel disk_dma_channel_chk #(.CW(CW)) i_chk (.*);

// File: tb/test_disk_dma_channel.sv
module test_disk_dma_channel;
    localparam int AW = 22;
    localparam int CW = 15;
    localparam logic [AW-1:0] FAULT_ADDR = 22'h000300;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          to_disk = 1'b0;
    logic [AW-1:0] start_addr = '0;
    logic [CW-2:0] start_count = '0;
    logic          sel_fd = 1'b0;
    logic          sel_hd = 1'b0;
    logic          fd_drq = 1'b0;
    logic [7:0]    fd_rdata = 8'h00;
    logic          hd_drq = 1'b0;
    logic [7:0]    hd_rdata = 8'h00;
    logic          fd_irq = 1'b0;
    logic          hd_irq = 1'b0;
    logic          kbd_irq = 1'b0;
    logic [15:0]   base_rdata = 16'h0;
    logic [15:0]   exp_rdata = 16'h0;
    logic          fd_rd_stb, fd_wr_stb, fd_miss;
    logic          hd_rd_stb, hd_wr_stb, hd_miss;
    logic [7:0]    ctl_wdata;
    logic [2:0]    irq_level;
    logic [AW-1:0] xlat_laddr;
    logic [AW-1:0] xlat_paddr;
    logic          xlat_ok;
    logic          base_cs, exp_cs, mem_we;
    logic [AW-2:0] mem_addr;
    logic [15:0]   mem_wdata;
    logic          dma_busy;
    logic [CW-1:0] dma_count;
    logic          err_nosel;

    always #2 clk = ~clk;

    // Identity translation with one faulting address
    assign xlat_paddr = xlat_laddr;
    assign xlat_ok    = (xlat_laddr != FAULT_ADDR);

    disk_dma_channel i_disk_dma_channel (.*);

    int n_chk = 0;
    int n_bad = 0;
    bit done_flag = 1'b0;

    logic [7:0]  fdq[$];
    logic [7:0]  hdq[$];
    bit          fd_sink = 1'b0, hd_sink = 1'b0, fd_hold = 1'b0;
    logic [15:0] bmem[int];
    logic [15:0] emem[int];
    logic [37:0] exp_mem[$];   // {bank, addr, data}
    logic [8:0]  exp_byte[$];  // {ctrl, byte}

    task automatic check(input bit ok, input string tag, input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    // Driver side of the scoreboard
    task automatic expect_mem(input bit bank, input logic [20:0] a, input logic [15:0] d);
        exp_mem.push_back({bank, a, d});
    endtask
    task automatic expect_byte(input bit ctrl, input logic [7:0] b);
        exp_byte.push_back({ctrl, b});
    endtask

    // Controller and memory models plus scoreboard monitor
    always @(posedge clk) begin
        if (fd_rd_stb && fdq.size() > 0) void'(fdq.pop_front());
        if (hd_rd_stb && hdq.size() > 0) void'(hdq.pop_front());
        if (fd_wr_stb || hd_wr_stb) begin
            if (exp_byte.size() == 0) check(1'b0, "R4 unexpected byte", ctl_wdata, 0);
            else begin
                logic [8:0] e;
                e = exp_byte.pop_front();
                check({hd_wr_stb, ctl_wdata} == e, "R4 byte order", {hd_wr_stb, ctl_wdata}, e);
            end
        end
        if ((base_cs || exp_cs) && mem_we) begin
            if (exp_mem.size() == 0) check(1'b0, "R3 unexpected mem write", mem_addr, 0);
            else begin
                logic [37:0] m;
                m = exp_mem.pop_front();
                check({exp_cs, mem_addr, mem_wdata} == m, "R3 mem write", {exp_cs, mem_addr, mem_wdata}, m);
            end
            if (base_cs) bmem[int'(mem_addr)] = mem_wdata;
            else emem[int'(mem_addr)] = mem_wdata;
        end
        if (base_cs && !mem_we) base_rdata <= bmem.exists(int'(mem_addr)) ? bmem[int'(mem_addr)] : 16'h0;
        if (exp_cs && !mem_we)  exp_rdata  <= emem.exists(int'(mem_addr)) ? emem[int'(mem_addr)] : 16'h0;
        fd_drq   <= !fd_hold && (fdq.size() > 0 || fd_sink);
        fd_rdata <= fdq.size() > 0 ? fdq[0] : 8'h00;
        hd_drq   <= hdq.size() > 0 || hd_sink;
        hd_rdata <= hdq.size() > 0 ? hdq[0] : 8'h00;
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic launch(input bit dir, input logic [AW-1:0] a, input logic [CW-2:0] c);
        to_disk = dir; start_addr = a; start_count = c; start = 1'b1;
        tick(1);
        start = 1'b0;
    endtask

    task automatic wait_idle(input string tag);
        int k = 0;
        while (dma_busy && k < 500) begin tick(1); k++; end
        tick(3);
        check(!dma_busy, tag, dma_busy, 0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        tick(3);
        @(negedge clk);
        check(!dma_busy && dma_count == 0 && irq_level == 0 && !err_nosel, "R12 reset", {dma_busy, dma_count, irq_level}, 0);
        check(!fd_miss && !hd_miss && !base_cs && !exp_cs && !fd_rd_stb && !hd_wr_stb, "R12 strobes", 1, 0);
        rst_n = 1'b1;
        tick(1);

        // R10 interrupt encoding
        kbd_irq = 1'b1; tick(2); @(negedge clk);
        check(irq_level == 3'd3, "R10 keyboard", irq_level, 3);
        hd_irq = 1'b1; tick(2); @(negedge clk);
        check(irq_level == 3'd2, "R10 hd over kbd", irq_level, 2);
        hd_irq = 1'b0; fd_irq = 1'b1; kbd_irq = 1'b0; tick(2); @(negedge clk);
        check(irq_level == 3'd2, "R10 fd", irq_level, 2);
        fd_irq = 1'b0; tick(2); @(negedge clk);
        check(irq_level == 3'd0, "R10 none", irq_level, 0);

        // R9 miss priority while idle
        fdq.push_back(8'h11); hdq.push_back(8'h22);
        tick(3); @(negedge clk);
        check(hd_miss && !fd_miss, "R9 hd first", {hd_miss, fd_miss}, 2'b10);
        hdq.delete(); tick(3); @(negedge clk);
        check(fd_miss && !hd_miss, "R9 fd only", {hd_miss, fd_miss}, 2'b01);
        fdq.delete(); tick(3); @(negedge clk);
        check(!fd_miss && !hd_miss, "R9 quiet", {hd_miss, fd_miss}, 0);

        // R1 R3 R7: floppy to base RAM, both drives selected, disk irq pending
        fd_irq = 1'b1;
        sel_fd = 1'b1; sel_hd = 1'b1;
        hdq.push_back(8'h77); hdq.push_back(8'h78);
        foreach (fdq[i]) ;
        fdq.push_back(8'hA1); fdq.push_back(8'hB2); fdq.push_back(8'hC3);
        fdq.push_back(8'hD4); fdq.push_back(8'hE5); fdq.push_back(8'hF6);
        expect_mem(1'b0, 21'h80, 16'hA1B2);
        expect_mem(1'b0, 21'h81, 16'hC3D4);
        expect_mem(1'b0, 21'h82, 16'hE5F6);
        tick(1);
        launch(1'b0, 22'h000100, 14'h3FFD);
        wait_idle("R7 ends busy");
        check(dma_count == 15'h3FFF, "R7 terminal count", dma_count, 15'h3FFF);
        check(xlat_laddr == 22'h000106, "R7 address step", xlat_laddr, 22'h106);
        check(hdq.size() == 2, "R1 hd untouched", hdq.size(), 2);
        check(irq_level == 3'd2, "R10 irq during run", irq_level, 2);
        fd_irq = 1'b0; hdq.delete();

        // R5 hard disk to expansion RAM
        sel_fd = 1'b0;
        hdq.push_back(8'h5A); hdq.push_back(8'hC3);
        expect_mem(1'b1, 21'h8, 16'h5AC3);
        tick(1);
        launch(1'b0, 22'h200010, 14'h3FFF);
        wait_idle("R5 done");
        check(exp_mem.size() == 0, "R5 expansion write seen", exp_mem.size(), 0);

        // R2 request held low: nothing moves
        sel_hd = 1'b0; sel_fd = 1'b1; fd_hold = 1'b1;
        fdq.push_back(8'h12); fdq.push_back(8'h34);
        tick(1);
        launch(1'b0, 22'h000400, 14'h3FF0);
        tick(10);
        check(dma_count == 15'h3FF0 && fdq.size() == 2, "R2 stalled", dma_count, 15'h3FF0);
        expect_mem(1'b0, 21'h200, 16'h1234);
        fd_hold = 1'b0;
        tick(6);
        check(dma_count == 15'h3FF1, "R2 resumes", dma_count, 15'h3FF1);
        start_addr = '0; start = 1'b1; to_disk = 1'b1; sel_fd = 1'b0;
        tick(1); start = 1'b0;
        tick(2);
        check(err_nosel, "R11 flag set", err_nosel, 1);
        tick(4);
        check(err_nosel && dma_busy && exp_mem.size() == 0, "R11 sticky no data", err_nosel, 1);

        // R4 base RAM to hard disk, also clears R11 flag on start
        sel_hd = 1'b1; hd_sink = 1'b1;
        bmem[32'h40] = 16'hA55A; bmem[32'h41] = 16'h1234;
        expect_byte(1'b1, 8'hA5); expect_byte(1'b1, 8'h5A);
        expect_byte(1'b1, 8'h12); expect_byte(1'b1, 8'h34);
        launch(1'b1, 22'h000080, 14'h3FFE);
        check(!err_nosel, "R11 cleared by start", err_nosel, 0);
        wait_idle("R4 done");
        check(exp_byte.size() == 0, "R4 all bytes", exp_byte.size(), 0);
        hd_sink = 1'b0; sel_hd = 1'b0;

        // R6 unpopulated read gives FFFF, unpopulated write is dropped
        sel_fd = 1'b1; fd_sink = 1'b1;
        expect_byte(1'b0, 8'hFF); expect_byte(1'b0, 8'hFF);
        launch(1'b1, 22'h380000, 14'h3FFF);
        wait_idle("R6 read done");
        check(exp_byte.size() == 0, "R6 open read", exp_byte.size(), 0);
        fd_sink = 1'b0;
        fdq.push_back(8'h99); fdq.push_back(8'h88);
        tick(1);
        launch(1'b0, 22'h380000, 14'h3FFF);
        wait_idle("R6 write done");
        check(xlat_laddr == 22'h380002 && fdq.size() == 0, "R6 write dropped", xlat_laddr, 22'h380002);

        // R8 access fault stops before the second word
        fdq.push_back(8'h01); fdq.push_back(8'h02);
        fdq.push_back(8'h03); fdq.push_back(8'h04);
        expect_mem(1'b0, 21'h17F, 16'h0102);
        tick(1);
        launch(1'b0, 22'h0002FE, 14'h3FF0);
        wait_idle("R8 stops");
        check(dma_count == 15'h3FF1 && xlat_laddr == FAULT_ADDR, "R8 state", dma_count, 15'h3FF1);
        check(fdq.size() == 2, "R8 bytes untouched", fdq.size(), 2);
        fdq.delete();

        tick(2);
        check(exp_mem.size() == 0 && exp_byte.size() == 0, "R3 scoreboard drained", exp_mem.size(), 0);
        finish_run();
    end
endmodule